// File: doc/BRIEF.md
# Timer Input Capture Channel Front-End

This block is the input half of one capture channel in a timer. It takes an asynchronous channel pin, brings it into the clock domain, and passes it through a digital glitch filter. The filtered level then feeds an edge detector that can pick rising edges, falling edges or both. Each edge that passes the detector becomes a one-cycle trigger pulse for a slave-mode controller.

The same edge pulse is also the capture command, but it goes through a capture divider first. Only every 1st, 2nd, 4th or 8th qualified edge copies the free-running timer count into the capture register. A capture sets a capture flag. A capture that arrives while that flag is still set also raises an overcapture flag. Both flags stay set until their clear inputs are pulsed. The divider starts counting again from zero whenever its setting changes or the channel is disabled.

Top module: `icap_frontend`

## Requirements
- R1: A transition on `chan_in` that is sampled at clock edge k, and that meets the filter, makes `trig_pulse` high in the cycle after edge k+3+`filt_len`. That is two synchroniser stages, `filt_len`+1 filter samples and one output register.
- R2: The filtered level changes only after the synchronised input has differed from it for `filt_len`+1 consecutive samples. A shorter excursion produces no trigger and no capture.
- R3: `edge_sel` picks which edges qualify. 0 selects rising edges, 1 selects falling edges, and 2 or 3 selects both.
- R4: `trig_pulse` is high for one cycle for every qualified edge, whatever the `psc_sel` setting. While `chan_en` is low, no edge qualifies.
- R5: A capture loads `cap_val` with the value of `cnt_val` at the same clock edge that raises `trig_pulse` for the capturing edge.
- R6: `psc_sel` sets the capture divider. Values 0, 1, 2 and 3 capture on every 1st, 2nd, 4th and 8th qualified edge. After reset, the first capture happens on the Nth qualified edge.
- R7: The divider edge count goes back to zero in any cycle in which `chan_en` is low or `psc_sel` differs from its value in the previous cycle. A qualified edge in a cycle where `psc_sel` changes counts as the first edge under the new setting.
- R8: A capture sets `cap_flag`. Pulsing `cap_clr` clears it. If a capture and `cap_clr` occur in the same cycle, the flag ends up set.
- R9: A capture that occurs while `cap_flag` is already set also sets `ovr_flag`. Pulsing `ovr_clr` clears it, and a simultaneous setting capture wins over the clear.
- R10: After a synchronous reset, `cap_val`, `cap_flag`, `ovr_flag` and `trig_pulse` are all zero.
- R11: `cap_val` holds its value in every cycle without a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; when low, no edges qualify and the divider is cleared |
| chan_in | input | 1 | Asynchronous channel input |
| cnt_val | input | CNT_W | Free-running timer count |
| filt_len | input | FILT_W | Filter length; the input must be stable for `filt_len`+1 samples |
| edge_sel | input | 2 | Edge polarity: 0 rising, 1 falling, 2 or 3 both |
| psc_sel | input | 2 | Capture divider: 1, 2, 4 or 8 edges per capture |
| cap_clr | input | 1 | Clears `cap_flag` |
| ovr_clr | input | 1 | Clears `ovr_flag` |
| cap_val | output | CNT_W | Captured count |
| cap_flag | output | 1 | Capture flag |
| ovr_flag | output | 1 | Overcapture flag |
| trig_pulse | output | 1 | One-cycle pulse per qualified edge, for the slave controller |

## Verification
The hardest cases to reach are the divider's hidden edge count being cleared by a disable or by a change of setting in the middle of a divide cycle. Other cases look alike from the outside unless the edge count is chosen so that a missing reset would cause a capture one edge early. The stimulus therefore gives a partial run of edges, then a disable or a setting change, and then exactly one edge fewer than the divider needs. It checks that no capture appears, and then checks that the very next edge does capture. A long random phase varies the filter length, the polarity, the divider and the clear inputs against a behavioural model. This reaches same-cycle clear/set collisions and filter runs that end exactly at the threshold.

// File: rtl/capch_pkg.sv
package capch_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_ANY  = 2'd2,
    EDGE_ANYB = 2'd3
  } edge_sel_e;

  // True when the level step cur/prev matches the selected polarity
  function automatic logic edge_hit(input logic [1:0] sel, input logic cur, input logic prev);
    logic up;
    logic dn;
    up = cur & ~prev;
    dn = ~cur & prev;
    case (edge_sel_e'(sel))
      EDGE_RISE: edge_hit = up;
      EDGE_FALL: edge_hit = dn;
      default:   edge_hit = up | dn;
    endcase
  endfunction

endpackage

// File: rtl/capch_filter.sv
module capch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [FILT_W-1:0] filt_len,
  output logic              lvl
);
  localparam logic [FILT_W-1:0] RUN_ONE = 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_W-1:0]      run_q;
  logic                   lvl_q;
  logic                   samp;

  // Synchroniser chain, one flop per stage
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b0;
        else     sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign samp = sync_q[SYNC_STAGES-1];

  // Run-length filter: accept a new level after filt_len+1 differing samples
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else if (samp == lvl_q) begin
      run_q <= '0;
    end else if (run_q >= filt_len) begin
      lvl_q <= samp;
      run_q <= '0;
    end else begin
      run_q <= run_q + RUN_ONE;
    end
  end

  assign lvl = lvl_q;
endmodule

// File: rtl/capch_edge.sv
module capch_edge
  import capch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl,
  input  logic       en,
  input  logic [1:0] sel,
  output logic       hit,
  output logic       trig
);
  logic lvl_d;
  logic trig_q;

  assign hit = en & edge_hit(sel, lvl, lvl_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      lvl_d  <= lvl;
      trig_q <= hit;
    end
  end

  assign trig = trig_q;
endmodule

// File: rtl/capch_presc.sv
module capch_presc #(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             en,
  input  logic [PSC_W-1:0] psc_sel,
  output logic             fire
);
  localparam int ECNT_W = (1 << PSC_W) - 1;
  localparam logic [ECNT_W-1:0] E_ONE = 1;

  logic [PSC_W-1:0]  psc_q;
  logic [ECNT_W-1:0] ecnt_q;
  logic [ECNT_W-1:0] base;
  logic [ECNT_W-1:0] term;
  logic              changed;

  // Terminal count 2**psc_sel - 1, built as a thermometer code
  always_comb begin
    term = '0;
    for (int i = 0; i < ECNT_W; i++) term[i] = (i < int'(psc_sel));
  end

  assign changed = (psc_sel != psc_q);
  assign base    = changed ? '0 : ecnt_q;
  assign fire    = hit & (base == term);

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q  <= '0;
      ecnt_q <= '0;
    end else begin
      psc_q <= psc_sel;
      if (hit)                   ecnt_q <= fire ? '0 : base + E_ONE;
      else if (!en || changed)   ecnt_q <= '0;
    end
  end
endmodule

// File: rtl/capch_capreg.sv
module capch_capreg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cap_clr,
  input  logic             ovr_clr,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag,
  output logic             ovr_flag
);
  logic [CNT_W-1:0] val_q;
  logic             flag_q;
  logic             ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q  <= '0;
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (fire) val_q <= cnt_val;
      if (fire)         flag_q <= 1'b1;
      else if (cap_clr) flag_q <= 1'b0;
      if (fire && flag_q) ovr_q <= 1'b1;
      else if (ovr_clr)   ovr_q <= 1'b0;
    end
  end

  assign cap_val  = val_q;
  assign cap_flag = flag_q;
  assign ovr_flag = ovr_q;
endmodule

// File: rtl/icap_frontend.sv
module icap_frontend #(
  parameter int CNT_W       = 16,
  parameter int FILT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_en,
  input  logic              chan_in,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic [FILT_W-1:0] filt_len,
  input  logic [1:0]        edge_sel,
  input  logic [1:0]        psc_sel,
  input  logic              cap_clr,
  input  logic              ovr_clr,
  output logic [CNT_W-1:0]  cap_val,
  output logic              cap_flag,
  output logic              ovr_flag,
  output logic              trig_pulse
);
  logic lvl;
  logic hit;
  logic fire;

  capch_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_W(FILT_W)) u_filter (
    .clk(clk), .rst(rst), .din(chan_in), .filt_len(filt_len), .lvl(lvl)
  );

  capch_edge u_edge (
    .clk(clk), .rst(rst), .lvl(lvl), .en(chan_en), .sel(edge_sel),
    .hit(hit), .trig(trig_pulse)
  );

  capch_presc #(.PSC_W(2)) u_presc (
    .clk(clk), .rst(rst), .hit(hit), .en(chan_en), .psc_sel(psc_sel), .fire(fire)
  );

  capch_capreg #(.CNT_W(CNT_W)) u_capreg (
    .clk(clk), .rst(rst), .fire(fire), .cnt_val(cnt_val),
    .cap_clr(cap_clr), .ovr_clr(ovr_clr),
    .cap_val(cap_val), .cap_flag(cap_flag), .ovr_flag(ovr_flag)
  );
endmodule

// File: rtl/icap_frontend_chk.sv
module icap_frontend_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             chan_en,
  input logic [1:0]       psc_sel,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] cap_val,
  input logic             cap_flag,
  input logic             ovr_flag,
  input logic             trig_pulse
);
  assert_trig_needs_en_R4: assert property (@(posedge clk) disable iff (rst)
    trig_pulse |-> $past(chan_en));

  assert_hold_without_trig_R11: assert property (@(posedge clk) disable iff (rst)
    !trig_pulse |-> $stable(cap_val));

  assert_flag_rise_on_trig_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_flag) |-> trig_pulse);

  assert_ovr_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_flag) |-> (trig_pulse && $past(cap_flag)));

  assert_div1_captures_R6: assert property (@(posedge clk) disable iff (rst)
    (trig_pulse && $past(psc_sel) == 2'd0) |-> cap_flag);

  assert_div1_value_R5: assert property (@(posedge clk) disable iff (rst)
    (trig_pulse && $past(psc_sel) == 2'd0) |-> (cap_val == $past(cnt_val)));
endmodule

bind icap_frontend icap_frontend_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .chan_en(chan_en), .psc_sel(psc_sel), .cnt_val(cnt_val),
  .cap_val(cap_val), .cap_flag(cap_flag), .ovr_flag(ovr_flag), .trig_pulse(trig_pulse)
);

// File: tb/icap_frontend_tb.sv
module icap_frontend_tb;
  localparam int CNT_W = 16;
  localparam int FILT_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chan_en = 1'b0;
  logic chan_in = 1'b0;
  logic [CNT_W-1:0] cnt_val = '0;
  logic [FILT_W-1:0] filt_len = '0;
  logic [1:0] edge_sel = 2'd0;
  logic [1:0] psc_sel = 2'd0;
  logic cap_clr = 1'b0;
  logic ovr_clr = 1'b0;
  logic [CNT_W-1:0] cap_val;
  logic cap_flag, ovr_flag, trig_pulse;

  icap_frontend #(.CNT_W(CNT_W), .FILT_W(FILT_W)) u_dut (
    .clk(clk), .rst(rst), .chan_en(chan_en), .chan_in(chan_in), .cnt_val(cnt_val),
    .filt_len(filt_len), .edge_sel(edge_sel), .psc_sel(psc_sel),
    .cap_clr(cap_clr), .ovr_clr(ovr_clr), .cap_val(cap_val),
    .cap_flag(cap_flag), .ovr_flag(ovr_flag), .trig_pulse(trig_pulse)
  );

  always #2.5 clk = ~clk;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;
  bit cmp_on = 0;
  int trig_cnt = 0;
  int cap_cnt = 0;
  logic [CNT_W-1:0] last_cap = '0;

  // behavioural reference state
  int s1m, s2m, fom, fpm, runm, ecm, pscpm;
  bit trigm, flagm, ovrm;
  int capm;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      s1m = 0; s2m = 0; fom = 0; fpm = 0; runm = 0; ecm = 0; pscpm = 0;
      trigm = 0; flagm = 0; ovrm = 0; capm = 0;
    end else begin
      bit rise, fall, ev, chg, cap;
      int dv, base;
      rise = (fom == 1) && (fpm == 0);
      fall = (fom == 0) && (fpm == 1);
      ev = chan_en && ((edge_sel == 0) ? rise : (edge_sel == 1) ? fall : (rise || fall));
      chg = (int'(psc_sel) != pscpm);
      dv = 1 << psc_sel;
      base = chg ? 0 : ecm;
      cap = 0;
      if (ev) begin
        if (base + 1 >= dv) begin cap = 1; ecm = 0; end
        else ecm = base + 1;
      end else if (!chan_en || chg) ecm = 0;
      trigm = ev;
      if (cap) begin
        if (flagm) ovrm = 1;
        else if (ovr_clr) ovrm = 0;
        flagm = 1;
        capm = int'(cnt_val);
      end else begin
        if (cap_clr) flagm = 0;
        if (ovr_clr) ovrm = 0;
      end
      fpm = fom;
      if (s2m == fom) runm = 0;
      else if (runm >= int'(filt_len)) begin fom = s2m; runm = 0; end
      else runm++;
      s2m = s1m;
      s1m = int'(chan_in);
      pscpm = int'(psc_sel);
    end
  end

  always @(negedge clk) begin
    cnt_val <= cnt_val + 1'b1;
    if (cmp_on) begin
      chk(trig_pulse == trigm, "R4", "trig_pulse", trig_pulse, trigm);
      chk(int'(cap_val) == capm, "R5", "cap_val", cap_val, capm);
      chk(cap_flag == flagm, "R8", "cap_flag", cap_flag, flagm);
      chk(ovr_flag == ovrm, "R9", "ovr_flag", ovr_flag, ovrm);
      if (trig_pulse) trig_cnt++;
      if (cap_val != last_cap) cap_cnt++;
      last_cap = cap_val;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic pulse(input int hi, input int lo);
    chan_in = 1'b1;
    repeat (hi) @(negedge clk);
    chan_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic settle();
    repeat (24) @(negedge clk);
  endtask

  task automatic clear_flags();
    cap_clr = 1; ovr_clr = 1;
    @(negedge clk);
    cap_clr = 0; ovr_clr = 0;
    @(negedge clk);
  endtask

  task automatic latency(input int fl, input string tag);
    int seen;
    filt_len = 4'(fl);
    settle();
    seen = 0;
    chan_in = 1'b1;
    for (int i = 1; i <= 24; i++) begin
      @(negedge clk);
      if (trig_pulse && seen == 0) seen = i;
    end
    chk(seen == 4 + fl, tag, "trigger latency", seen, 4 + fl);
    chan_in = 1'b0;
    settle();
  endtask

  int t0, c0;

  initial begin
    repeat (4) @(negedge clk);
    cmp_on = 1;
    // R10: reset state
    chk(cap_val == 0 && !cap_flag && !ovr_flag && !trig_pulse, "R10", "reset outputs",
        {cap_flag, ovr_flag, trig_pulse}, 0);
    rst = 0;
    chan_en = 1;
    @(negedge clk);

    // R1: latency through sync, filter and output register
    latency(0, "R1");
    latency(3, "R1");

    // R2: short glitches are filtered away
    filt_len = 4'd3; settle();
    t0 = trig_cnt;
    for (int k = 0; k < 4; k++) pulse(3, 6);
    settle();
    chk(trig_cnt == t0, "R2", "glitch triggers", trig_cnt - t0, 0);
    pulse(4, 6); settle();
    chk(trig_cnt == t0 + 1, "R2", "long pulse triggers", trig_cnt - t0, 1);

    // R3: polarity selection
    filt_len = 0; edge_sel = 2'd1; settle();
    t0 = trig_cnt;
    for (int k = 0; k < 5; k++) pulse(3, 3);
    settle();
    chk(trig_cnt - t0 == 5, "R3", "falling edge count", trig_cnt - t0, 5);
    edge_sel = 2'd2; settle();
    t0 = trig_cnt;
    for (int k = 0; k < 5; k++) pulse(3, 3);
    settle();
    chk(trig_cnt - t0 == 10, "R3", "both edge count", trig_cnt - t0, 10);
    edge_sel = 2'd0; settle();

    // R6: divider ratios, triggers unaffected
    psc_sel = 2'd2; settle();
    t0 = trig_cnt; c0 = cap_cnt;
    for (int k = 0; k < 12; k++) pulse(3, 3);
    settle();
    chk(cap_cnt - c0 == 3, "R6", "captures at div 4", cap_cnt - c0, 3);
    chk(trig_cnt - t0 == 12, "R4", "triggers at div 4", trig_cnt - t0, 12);
    psc_sel = 2'd3; settle();
    c0 = cap_cnt;
    for (int k = 0; k < 16; k++) pulse(3, 3);
    settle();
    chk(cap_cnt - c0 == 2, "R6", "captures at div 8", cap_cnt - c0, 2);

    // R7: disable clears the edge count
    c0 = cap_cnt;
    for (int k = 0; k < 5; k++) pulse(3, 3);
    settle();
    chan_en = 0; repeat (3) @(negedge clk); chan_en = 1; settle();
    for (int k = 0; k < 7; k++) pulse(3, 3);
    settle();
    chk(cap_cnt == c0, "R7", "no capture after disable", cap_cnt - c0, 0);
    pulse(3, 3); settle();
    chk(cap_cnt - c0 == 1, "R7", "capture on 8th after disable", cap_cnt - c0, 1);
    // R7: setting change clears the edge count
    c0 = cap_cnt;
    for (int k = 0; k < 5; k++) pulse(3, 3);
    settle();
    psc_sel = 2'd2; settle();
    for (int k = 0; k < 3; k++) pulse(3, 3);
    settle();
    chk(cap_cnt == c0, "R7", "no capture after setting change", cap_cnt - c0, 0);
    pulse(3, 3); settle();
    chk(cap_cnt - c0 == 1, "R7", "capture on 4th after change", cap_cnt - c0, 1);

    // R4: disabled channel gives no triggers
    chan_en = 0; settle();
    t0 = trig_cnt;
    for (int k = 0; k < 4; k++) pulse(3, 3);
    settle();
    chk(trig_cnt == t0, "R4", "triggers while disabled", trig_cnt - t0, 0);
    chan_en = 1; settle();

    // R8, R9: flags
    psc_sel = 2'd0; settle();
    clear_flags();
    chk(!cap_flag && !ovr_flag, "R8", "flags after clear", {cap_flag, ovr_flag}, 0);
    pulse(3, 3); settle();
    chk(cap_flag && !ovr_flag, "R8", "flag after one capture", {cap_flag, ovr_flag}, 2);
    pulse(3, 3); settle();
    chk(ovr_flag, "R9", "overcapture set", ovr_flag, 1);
    clear_flags();
    chk(!cap_flag && !ovr_flag, "R9", "flags cleared", {cap_flag, ovr_flag}, 0);
    c0 = int'(cap_val);
    settle();
    chk(int'(cap_val) == c0, "R11", "value held", cap_val, c0);

    // random phase compared against the model each cycle
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(3) == 0) chan_in = ~chan_in;
      if ($urandom_range(199) == 0) filt_len = 4'($urandom_range(3));
      if ($urandom_range(149) == 0) edge_sel = 2'($urandom_range(3));
      if ($urandom_range(99) == 0) psc_sel = 2'($urandom_range(3));
      if ($urandom_range(299) == 0) chan_en = ~chan_en;
      cap_clr = ($urandom_range(15) == 0);
      ovr_clr = ($urandom_range(15) == 0);
      @(negedge clk);
    end
    cap_clr = 0; ovr_clr = 0;
    settle();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule